// File: doc/BRIEF.md
# Three-Button Confirmed-Change Debouncer

This block filters three active-low push-button lines so that downstream logic sees only deliberate presses and releases. The raw lines are first brought into the clock domain by a two-stage synchroniser. On each system tick while the block is idle, the synchronised lines are compared with a registered stable image of the buttons. Any mismatch freezes a mask of the mismatched buttons and starts one shared countdown. When the countdown runs out, only the masked buttons that still mismatch are flipped in the stable image.

Each commit produces a single-clock event pulse. A message builder downstream uses this pulse to learn that fresh button data is ready. A mismatch that disappears before the countdown ends is dropped without an event. A mismatch on a button outside the frozen mask waits until the block is idle again, and then it starts a countdown of its own.

Top module: `btn_confirm_debounce`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `btn_level_o` is 3'b111 (all released) and `evt_o` is 0.
- R2: A button held low (0) on `btn_raw_n_i` through reset is committed as 0 on the 13th tick after the synchroniser settles. This happens because the image starts at all ones.
- R3: A tick that arrives while idle, with the synchronised lines differing from the image, starts a wait. The commit happens on the 12th tick after that starting tick and never earlier. Bit i of `btn_raw_n_i` maps to bit i of `btn_level_o`.
- R4: The mask is fixed for the whole wait. A button that starts to differ during a wait is not committed at that wait's expiry. It is committed 13 ticks later, through a new wait.
- R5: At expiry only the masked buttons that still differ change. A masked button that has returned to its image value keeps its value.
- R6: When no masked button still differs at expiry, `btn_level_o` is unchanged, no event is raised, and the block goes back to idle.
- R7: `evt_o` is high for exactly one clock, in the cycle after the commit tick edge. It is high only when `btn_level_o` changes in that same cycle.
- R8: With `tick_i` low, the countdown, the mask and `btn_level_o` hold their values and `evt_o` stays 0, whatever the raw lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle sampling enable |
| btn_raw_n_i | input | 3 | Raw asynchronous active-low buttons |
| btn_level_o | output | 3 | Debounced button levels (0 = pressed) |
| evt_o | output | 1 | One-clock pulse on each committed change |

## Verification
The expiry of a wait and the appearance of a new mismatch can fall on the same tick. The new mismatch is on a button outside the frozen mask, so the two compete for the same image update. The bench provokes this by pressing one button and then, a few ticks into the wait, pressing a second one. It judges the result by checking three things: the first expiry commits only the first button with one event, the second button stays released at that point, and the second button commits with its own event exactly 13 ticks later.

// File: rtl/btn_db_pkg.sv
package btn_db_pkg;

    localparam int unsigned DEF_N_BTN         = 3;
    localparam int unsigned DEF_CONFIRM_TICKS = 12;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic {
        DB_IDLE = 1'b0,
        DB_WAIT = 1'b1
    } db_state_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int unsigned N_BTN  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_BTN-1:0] raw_i,
    output logic [N_BTN-1:0] sync_o
);
    logic [N_BTN-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '1;
                    else       stage_q[s] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '1;
                    else       stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/btn_confirm_ctl.sv
module btn_confirm_ctl
    import btn_db_pkg::*;
#(
    parameter int unsigned N_BTN         = 3,
    parameter int unsigned CONFIRM_TICKS = 12,
    localparam int unsigned CNT_W        = cnt_width(CONFIRM_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [N_BTN-1:0] sampled_i,
    input  logic [N_BTN-1:0] image_i,
    output logic             commit_o,
    output logic [N_BTN-1:0] flip_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [N_BTN-1:0] mask_o
);
    db_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [N_BTN-1:0] mask_q;
    logic [N_BTN-1:0] diff;
    logic             expire;

    always_comb begin
        diff     = sampled_i ^ image_i;
        expire   = tick_i && (state_q == DB_WAIT) && (cnt_q == CNT_W'(1));
        flip_o   = diff & mask_q;
        commit_o = expire && (|flip_o);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else if (tick_i) begin
            unique case (state_q)
                DB_IDLE: begin
                    if (|diff) begin
                        mask_q  <= diff;
                        cnt_q   <= CNT_W'(CONFIRM_TICKS);
                        state_q <= DB_WAIT;
                    end
                end
                DB_WAIT: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) state_q <= DB_IDLE;
                end
                default: state_q <= DB_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == DB_WAIT);
    assign cnt_o  = cnt_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/btn_image.sv
module btn_image #(
    parameter int unsigned N_BTN = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             commit_i,
    input  logic [N_BTN-1:0] flip_i,
    output logic [N_BTN-1:0] level_o,
    output logic             evt_o
);
    logic [N_BTN-1:0] level_q;
    logic             evt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= '1;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= commit_i;
            if (commit_i) level_q <= level_q ^ flip_i;
        end
    end

    assign level_o = level_q;
    assign evt_o   = evt_q;
endmodule

// File: rtl/btn_confirm_debounce.sv
module btn_confirm_debounce
    import btn_db_pkg::*;
#(
    parameter int unsigned N_BTN         = DEF_N_BTN,
    parameter int unsigned CONFIRM_TICKS = DEF_CONFIRM_TICKS,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
    localparam int unsigned CNT_W        = cnt_width(CONFIRM_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [N_BTN-1:0] btn_raw_n_i,
    output logic [N_BTN-1:0] btn_level_o,
    output logic             evt_o
);
    logic [N_BTN-1:0] sampled;
    logic             commit;
    logic [N_BTN-1:0] flip;
    logic             wait_busy;
    logic [CNT_W-1:0] wait_cnt;
    logic [N_BTN-1:0] wait_mask;

    btn_sync #(
        .N_BTN  (N_BTN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (btn_raw_n_i),
        .sync_o (sampled)
    );

    btn_confirm_ctl #(
        .N_BTN         (N_BTN),
        .CONFIRM_TICKS (CONFIRM_TICKS)
    ) u_ctl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .sampled_i (sampled),
        .image_i   (btn_level_o),
        .commit_o  (commit),
        .flip_o    (flip),
        .busy_o    (wait_busy),
        .cnt_o     (wait_cnt),
        .mask_o    (wait_mask)
    );

    btn_image #(
        .N_BTN (N_BTN)
    ) u_image (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .commit_i (commit),
        .flip_i   (flip),
        .level_o  (btn_level_o),
        .evt_o    (evt_o)
    );
endmodule

// File: rtl/btn_confirm_debounce_chk.sv
module btn_confirm_debounce_chk #(
    parameter int unsigned N_BTN         = 3,
    parameter int unsigned CONFIRM_TICKS = 12,
    parameter int unsigned CNT_W         = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [N_BTN-1:0] level,
    input logic             evt,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic [N_BTN-1:0] mask
);
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R7
    AST_LEVEL_MOVES_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> evt); // R7
    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(tick)); // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ($stable(cnt) && $stable(mask) && $stable(level))); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= CONFIRM_TICKS); // R3
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mask)); // R4
    AST_COMMIT_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        evt |-> (((level ^ $past(level)) & ~$past(mask)) == '0)); // R5
endmodule

bind btn_confirm_debounce btn_confirm_debounce_chk #(
    .N_BTN         (N_BTN),
    .CONFIRM_TICKS (CONFIRM_TICKS),
    .CNT_W         (CNT_W)
) u_chk (
    .clk   (clk_i),
    .rst   (rst_i),
    .tick  (tick_i),
    .level (btn_level_o),
    .evt   (evt_o),
    .busy  (wait_busy),
    .cnt   (wait_cnt),
    .mask  (wait_mask)
);

// File: tb/btn_confirm_debounce_bench.sv
module btn_confirm_debounce_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 8;

    // {raw[2:0], ticks[7:0], expected level[2:0], expected events[3:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {3'b111, 8'd20, 3'b111, 4'd0},   // idle, nothing pressed
        {3'b110, 8'd11, 3'b111, 4'd0},   // R3: not yet committed
        {3'b110, 8'd2,  3'b110, 4'd1},   // R3: commit on 12th tick after start
        {3'b100, 8'd13, 3'b100, 4'd1},
        {3'b111, 8'd13, 3'b111, 4'd1},
        {3'b011, 8'd1,  3'b111, 4'd0},   // glitch starts a wait
        {3'b111, 8'd12, 3'b111, 4'd0},   // R6: gone at expiry
        {3'b000, 8'd13, 3'b000, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] raw = 3'b111;
    logic [2:0] level;
    logic       evt;

    int n_tests = 0;
    int n_fail  = 0;
    int evt_cnt = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_confirm_debounce u_btn_confirm_debounce (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .btn_raw_n_i (raw),
        .btn_level_o (level),
        .evt_o       (evt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_raw(input logic [2:0] v);
        raw = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (evt) evt_cnt++;
        @(negedge clk);
        if (evt) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7: evt held a second cycle, actual 1 expected 0");
        end
    endtask

    task automatic run_ticks(input int n);
        evt_cnt = 0;
        for (int i = 0; i < n; i++) pulse_tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 level in reset", int'(level), 7);
        check("R1 evt in reset", int'(evt), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 level after reset", int'(level), 7);
        check("R1 evt after reset", int'(evt), 0);

        for (int v = 0; v < NVEC; v++) begin
            set_raw(VEC[v][17:15]);
            run_ticks(int'(VEC[v][14:7]));
            check($sformatf("R3/R6 vector %0d level", v), int'(level), int'(VEC[v][6:4]));
            check($sformatf("R7 vector %0d events", v), evt_cnt, int'(VEC[v][3:0]));
        end

        // R2: button held through reset
        raw = 3'b101;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 level after second reset", int'(level), 7);
        repeat (3) @(negedge clk);
        run_ticks(12);
        check("R2 not yet committed", int'(level), 7);
        run_ticks(1);
        check("R2 held-low button committed", int'(level), 5);
        check("R2 one event", evt_cnt, 1);

        // R8: no tick, nothing moves
        raw = 3'b111;
        evt_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (evt) evt_cnt++;
        end
        check("R8 level frozen without tick", int'(level), 5);
        check("R8 no event without tick", evt_cnt, 0);
        run_ticks(13);
        check("R8 release committed once ticking", int'(level), 7);

        // R4: second press lands during a wait
        set_raw(3'b110);
        run_ticks(3);
        set_raw(3'b100);
        run_ticks(9);
        check("R4 no commit before expiry", int'(level), 7);
        run_ticks(1);
        check("R4 only masked button committed", int'(level), 6);
        check("R4 one event at expiry", evt_cnt, 1);
        run_ticks(13);
        check("R4 late button via new wait", int'(level), 4);
        check("R4 late button event", evt_cnt, 1);

        // R5: one masked button reverts before expiry
        set_raw(3'b111);
        run_ticks(4);
        set_raw(3'b101);
        run_ticks(9);
        check("R5 only still-differing bit flips", int'(level), 5);
        check("R5 one event", evt_cnt, 1);
        run_ticks(13);
        check("R5 image stays put", int'(level), 5);
        check("R6 no spurious event", evt_cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule